// File: doc/BRIEF.md
# Standby-on-Await Power Controller

This block places a processor core into a low-power standby when software writes a control word with the await bit set. Standby does not start at once. The controller first lets exactly one more instruction retire. It then holds the core still until every serial and host-port word transfer engine reports idle. Only after that does it gate the core clock enable. The interrupt-detection path runs on the free-running clock the whole time, so any interrupt request can wake the core.

On wake-up the controller clears the await bit and turns the core clock back on. It then raises a hold that keeps the interrupt vector from being taken until one instruction has retired. An interrupt that arrives while entry is still pending cancels the entry: the await bit clears and the clock is never gated. All four outputs are registered. Each one changes on the clock edge that samples its cause.

Top module: `standby_ctrl`

## Requirements
- R1: After synchronous reset, core_clk_en is 1 and sleeping, await_bit and isr_hold are 0.
- R2: A control write while running (await_bit 0 and isr_hold 0) whose data has bit 15 set makes await_bit 1 on the next clock. core_clk_en stays 1 until an instruction retires.
- R3: A control write with bit 15 clear has no effect. Any control write made while await_bit or isr_hold is 1 also has no effect, so a write of zero during entry does not clear await_bit.
- R4: While entry is pending, the first retire strobe causes core_clk_en to be 0 on the next clock. Before that strobe, core_clk_en stays 1.
- R5: sleeping rises only on the clock after a cycle in which every bit of xfer_busy was 0 and the single instruction had retired. While a transfer is busy, core_clk_en is 0 and sleeping is 0.
- R6: sleeping is 1 only in standby, and whenever sleeping is 1, core_clk_en is 0. A retire strobe during standby changes nothing.
- R7: Any bit of irq set during standby gives, on the next clock, core_clk_en 1, sleeping 0, await_bit 0 and isr_hold 1.
- R8: isr_hold stays 1 until a retire strobe arrives, and it is 0 on the clock after that strobe.
- R9: Any bit of irq set while entry is pending gives, on the next clock, await_bit 0, core_clk_en 1, sleeping 0 and isr_hold 0. This applies whether or not the instruction has retired.
- R10: An interrupt while await_bit is 0 and isr_hold is 0 leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, also used for interrupt detection |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | CTRL_W (16) | Control write data; bit AWAIT_BIT (15) requests standby |
| retire | input | 1 | One-cycle strobe per retired instruction |
| xfer_busy | input | NUM_XFER (2) | Busy flags of the word transfer engines |
| irq | input | NUM_IRQ (8) | Interrupt request lines |
| core_clk_en | output | 1 | Core clock enable |
| sleeping | output | 1 | Standby status |
| await_bit | output | 1 | Current value of the await control bit |
| isr_hold | output | 1 | Holds back interrupt vectoring until one instruction retires |

## Verification
Every output is due exactly one clock after the inputs that cause it. The bench drives its inputs 2 ns after a rising edge. It then compares all four outputs against a behavioural mode model 2 ns after the next rising edge. Corner cases are timed so that their causes fall on precise cycles: an interrupt in the same cycle as the retire during entry, transfer busy released several cycles after the retire, and a retire strobe during standby.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } psc_state_e;
endpackage

// File: rtl/psc_ctrl_decode.sv
module psc_ctrl_decode #(
  parameter int CTRL_W    = 16,
  parameter int AWAIT_BIT = 15
) (
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              await_req
);
  localparam logic [CTRL_W-1:0] AWAIT_MASK = CTRL_W'(1) << AWAIT_BIT;

  always_comb await_req = wr_en && (|(wr_data & AWAIT_MASK));
endmodule

// File: rtl/psc_wake_detect.sv
module psc_wake_detect #(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               wake
);
  logic any_irq;
  always_comb any_irq = |irq;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      always_comb wake = any_irq;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else if (SYNC_STAGES == 1) pipe <= any_irq;
        else pipe <= {pipe[SYNC_STAGES-2:0], any_irq};
      end
      always_comb wake = pipe[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic await_req,
  input  logic retire,
  input  logic xfer_idle,
  input  logic wake,
  output logic core_clk_en,
  output logic sleeping,
  output logic await_bit,
  output logic isr_hold
);
  psc_state_e state_q, state_n;
  logic       ret_seen_q, ret_seen_n;
  logic       await_q, await_n;

  always_comb begin
    state_n    = state_q;
    ret_seen_n = ret_seen_q;
    await_n    = await_q;
    unique case (state_q)
      ST_RUN: begin
        if (await_req) begin
          state_n    = ST_DRAIN;
          await_n    = 1'b1;
          ret_seen_n = 1'b0;
        end
      end
      ST_DRAIN: begin
        if (wake) begin
          state_n    = ST_RUN;
          await_n    = 1'b0;
          ret_seen_n = 1'b0;
        end else if (ret_seen_q || retire) begin
          ret_seen_n = 1'b1;
          if (xfer_idle) state_n = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          state_n    = ST_WAKE;
          await_n    = 1'b0;
          ret_seen_n = 1'b0;
        end
      end
      ST_WAKE: begin
        if (retire) state_n = ST_RUN;
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      ret_seen_q  <= 1'b0;
      await_q     <= 1'b0;
      core_clk_en <= 1'b1;
      sleeping    <= 1'b0;
      isr_hold    <= 1'b0;
    end else begin
      state_q     <= state_n;
      ret_seen_q  <= ret_seen_n;
      await_q     <= await_n;
      core_clk_en <= !((state_n == ST_SLEEP) || ((state_n == ST_DRAIN) && ret_seen_n));
      sleeping    <= (state_n == ST_SLEEP);
      isr_hold    <= (state_n == ST_WAKE);
    end
  end

  always_comb await_bit = await_q;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int CTRL_W      = 16,
  parameter int AWAIT_BIT   = 15,
  parameter int NUM_XFER    = 2,
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic                retire,
  input  logic [NUM_XFER-1:0] xfer_busy,
  input  logic [NUM_IRQ-1:0]  irq,
  output logic                core_clk_en,
  output logic                sleeping,
  output logic                await_bit,
  output logic                isr_hold
);
  localparam bit BIT_OK = (AWAIT_BIT < CTRL_W);

  logic await_req;
  logic wake;
  logic xfer_idle;

  initial begin
    if (!BIT_OK) $error("AWAIT_BIT outside control word");
  end

  always_comb xfer_idle = ~|xfer_busy;

  psc_ctrl_decode #(.CTRL_W(CTRL_W), .AWAIT_BIT(AWAIT_BIT)) u_dec (
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .await_req (await_req)
  );

  psc_wake_detect #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk  (clk),
    .rst  (rst),
    .irq  (irq),
    .wake (wake)
  );

  psc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .await_req   (await_req),
    .retire      (retire),
    .xfer_idle   (xfer_idle),
    .wake        (wake),
    .core_clk_en (core_clk_en),
    .sleeping    (sleeping),
    .await_bit   (await_bit),
    .isr_hold    (isr_hold)
  );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk #(
  parameter int CTRL_W      = 16,
  parameter int AWAIT_BIT   = 15,
  parameter int NUM_XFER    = 2,
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [CTRL_W-1:0]   wr_data,
  input logic                retire,
  input logic [NUM_XFER-1:0] xfer_busy,
  input logic [NUM_IRQ-1:0]  irq,
  input logic                core_clk_en,
  input logic                sleeping,
  input logic                await_bit,
  input logic                isr_hold
);
  localparam bit DIRECT = (SYNC_STAGES == 0);

  assert_rst_state_R1: assert property (@(posedge clk)
    rst |=> (core_clk_en && !sleeping && !await_bit && !isr_hold));

  assert_await_set_R2: assert property (@(posedge clk) disable iff (rst)
    (!await_bit && !isr_hold && wr_en && wr_data[AWAIT_BIT] && !(DIRECT && |irq))
      |=> (await_bit && core_clk_en));

  assert_clear_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!await_bit && !isr_hold && wr_en && !wr_data[AWAIT_BIT]) |=> !await_bit);

  assert_clk_on_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(await_bit) |-> core_clk_en);

  assert_idle_before_sleep_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sleeping) |-> ($past(xfer_busy) == '0));

  assert_sleep_gated_R6: assert property (@(posedge clk) disable iff (rst)
    sleeping |-> !core_clk_en);

  assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (DIRECT && sleeping && |irq) |=> (core_clk_en && isr_hold && !await_bit && !sleeping));

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
    (isr_hold && retire) |=> !isr_hold);

  assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (DIRECT && await_bit && !sleeping && |irq)
      |=> (!await_bit && core_clk_en && !sleeping && !isr_hold));
endmodule

bind standby_ctrl standby_ctrl_chk #(
  .CTRL_W(CTRL_W), .AWAIT_BIT(AWAIT_BIT), .NUM_XFER(NUM_XFER),
  .NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/standby_ctrl_test.sv
`timescale 1ns/1ps
module standby_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        retire = 1'b0;
  logic [1:0]  xfer_busy = '0;
  logic [7:0]  irq = '0;
  logic        core_clk_en, sleeping, await_bit, isr_hold;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  string cur_req  = "R1";

  // behavioural model: 0 run, 1 pending, 2 standby, 3 waking
  int m_mode = 0;
  bit m_ret  = 0;

  always #10 clk = ~clk;

  standby_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .retire(retire),
    .xfer_busy(xfer_busy), .irq(irq), .core_clk_en(core_clk_en),
    .sleeping(sleeping), .await_bit(await_bit), .isr_hold(isr_hold)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_mode = 0; m_ret = 0;
    end else begin
      case (m_mode)
        0: if (wr_en && wr_data[15]) begin m_mode = 1; m_ret = 0; end
        1: if (irq != 0) begin m_mode = 0; m_ret = 0; end
           else if (m_ret || retire) begin
             m_ret = 1;
             if (xfer_busy == 0) m_mode = 2;
           end
        2: if (irq != 0) begin m_mode = 3; m_ret = 0; end
        default: if (retire) m_mode = 0;
      endcase
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic r,
                      input logic [1:0] b, input logic [7:0] q);
    wr_en = w; wr_data = d; retire = r; xfer_busy = b; irq = q;
    @(posedge clk); #2;
    chk("core_clk_en", core_clk_en, !(m_mode == 2 || (m_mode == 1 && m_ret)));
    chk("sleeping",    sleeping,    m_mode == 2);
    chk("await_bit",   await_bit,   m_mode == 1 || m_mode == 2);
    chk("isr_hold",    isr_hold,    m_mode == 3);
  endtask

  task automatic idle(input int n, input logic [1:0] b);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, b, 8'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cur_req = "R1"; step(1'b0, 16'h0, 1'b0, 2'b00, 8'h0);
    rst = 1'b0;
    idle(2, 2'b00);
    // R10: interrupt with no await pending
    cur_req = "R10"; step(1'b0, 16'h0, 1'b0, 2'b00, 8'h01); idle(1, 2'b00);
    // R3: write with bit 15 clear
    cur_req = "R3"; step(1'b1, 16'h7FFF, 1'b0, 2'b00, 8'h0); idle(1, 2'b00);
    // R2: standby request
    cur_req = "R2"; step(1'b1, 16'h8000, 1'b0, 2'b00, 8'h0); idle(2, 2'b00);
    // R3: writes during entry ignored
    cur_req = "R3"; step(1'b1, 16'h0000, 1'b0, 2'b00, 8'h0);
    step(1'b1, 16'h8000, 1'b0, 2'b00, 8'h0);
    // R4: first retire gates the clock; idle engines -> standby
    cur_req = "R4"; step(1'b0, 16'h0, 1'b1, 2'b00, 8'h0);
    // R6: standby, retire strobes ignored
    cur_req = "R6"; idle(3, 2'b00); step(1'b0, 16'h0, 1'b1, 2'b00, 8'h0);
    step(1'b1, 16'h0000, 1'b0, 2'b00, 8'h0);
    // R7: wake
    cur_req = "R7"; step(1'b0, 16'h0, 1'b0, 2'b00, 8'h80);
    // R8: hold until a retire; writes ignored while holding
    cur_req = "R8"; idle(3, 2'b00); step(1'b1, 16'h8000, 1'b0, 2'b00, 8'h0);
    step(1'b0, 16'h0, 1'b1, 2'b00, 8'h0); idle(2, 2'b00);
    // R5: transfer in progress delays standby
    cur_req = "R5"; step(1'b1, 16'hFFFF, 1'b0, 2'b01, 8'h0);
    step(1'b0, 16'h0, 1'b1, 2'b01, 8'h0);
    idle(4, 2'b10); idle(2, 2'b11); idle(3, 2'b00);
    cur_req = "R7"; step(1'b0, 16'h0, 1'b0, 2'b00, 8'h20);
    step(1'b0, 16'h0, 1'b1, 2'b00, 8'h0); idle(1, 2'b00);
    // R9: interrupt before retire cancels entry
    cur_req = "R9"; step(1'b1, 16'h8000, 1'b0, 2'b00, 8'h0);
    step(1'b0, 16'h0, 1'b0, 2'b00, 8'h04); idle(2, 2'b00);
    // R9: interrupt in same cycle as retire
    step(1'b1, 16'h8000, 1'b0, 2'b00, 8'h0);
    step(1'b0, 16'h0, 1'b1, 2'b00, 8'h02); idle(1, 2'b00);
    // R9: interrupt after retire while busy
    step(1'b1, 16'h8000, 1'b0, 2'b01, 8'h0);
    step(1'b0, 16'h0, 1'b1, 2'b01, 8'h0); idle(2, 2'b01);
    step(1'b0, 16'h0, 1'b0, 2'b01, 8'h40); idle(3, 2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule